// File: doc/BRIEF.md
# Switch-Level MOS Device Evaluator

This block works out what one switch-level transistor device puts on its output node. The data side carries a four-state logic value and a three-bit drive strength. Each control side carries a four-state value. A device-type select chooses an n-channel switch, a p-channel switch, or a complementary pair with separate n and p controls. A resistive flag makes the device lower the strength it passes by a further step.

The result is a four-state value, a strength, and two flags. The flags mark the ambiguous results that an unknown control produces: "0 or z" and "1 or z". The block is meant to run inside a hardware switch-level simulation engine. There, one instance is shared in time across the devices of a netlist, and it feeds a separate net-resolution stage. The inputs are sampled on each rising clock edge, and the result is registered, so it appears one cycle later.

Encodings used throughout:
- Value: 0 = logic 0, 1 = logic 1, 2 = x, 3 = z.
- Strength: 7 = supply, 6 = strong, 5 = pull, 4 = large capacitor, 3 = weak, 2 = medium capacitor, 1 = small capacitor, 0 = high impedance.
- Device select: 0 = n switch (uses `ctl_n`), 1 = p switch (uses `ctl_p`), 2 = complementary pair (uses both), 3 = reserved.

Top module: `swl_device_eval`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become value 3 (z), strength 0, with `out_l` and `out_h` low.
- R2: Outside reset, the outputs after a rising edge depend only on the inputs sampled at that edge.
- R3: For device select 0, `ctl_n` = 1 passes the data value, and `ctl_n` = 0 gives value 3 with strength 0.
- R4: For device select 1, `ctl_p` = 0 passes the data value, and `ctl_p` = 1 gives value 3 with strength 0.
- R5: When the selected control is 2 or 3 (x or z), the result depends on the data. Data 0 gives value 0 with `out_l` high. Data 1 gives value 1 with `out_h` high. Data 2 gives value 2 with both flags low. The strength is the reduced data strength in each case.
- R6: Data whose value is 3, or whose strength is 0, gives value 3 with strength 0 and both flags low. This holds for every control value and device select.
- R7: With `resistive` low, a conducting device turns strength 7 into 6 and passes every other strength unchanged.
- R8: With `resistive` high, strengths 7 and 6 become 5, 5 becomes 3, 4 and 3 become 2, 2 becomes 1, 1 stays 1, and 0 stays 0.
- R9: For device select 2, the pair conducts when `ctl_n` = 1 or `ctl_p` = 0. It is off when `ctl_n` = 0 and `ctl_p` = 1. In every other case it gives the ambiguous result of R5.
- R10: Device select 3 always gives value 3 with strength 0.
- R11: The output strength never exceeds the data strength. A z output always has strength 0. `out_l` and `out_h` are never high together, and a raised flag is always paired with value 0 (`out_l`) or value 1 (`out_h`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_val | input | 2 | Data value (0, 1, x, z) |
| in_str | input | 3 | Data strength (7 supply down to 0 high impedance) |
| ctl_n | input | 2 | Control of the n-channel side |
| ctl_p | input | 2 | Control of the p-channel side |
| dev_sel | input | 2 | Device type select |
| resistive | input | 1 | Resistive device flag |
| out_val | output | 2 | Resulting value |
| out_str | output | 3 | Resulting strength |
| out_l | output | 1 | Ambiguous "0 or z" result |
| out_h | output | 1 | Ambiguous "1 or z" result |

## Verification
The bench aims at the corner cases below. Each one is listed with what a faulty design would do there:
- Supply-strength data on a plain switch. A design that skips the reduction would pass strength 7.
- A z control versus an x control. A design that treats z control as off would give z instead of an ambiguous L or H.
- Strength-0 data carrying a 0 or 1 value. A faulty design would output a driven value at no strength.
- The complementary pair with one side on and the other side unknown. A faulty merge would give an ambiguous result where the pair conducts.
- Each step of the resistive ladder, where an off-by-one table row shows up as a wrong strength code.

// File: rtl/swl_pkg.sv
package swl_pkg;
  parameter int VAL_W = 2;
  parameter int STR_W = 3;
  parameter int DEV_W = 2;

  typedef enum logic [VAL_W-1:0] {
    V_ZERO = 2'd0,
    V_ONE  = 2'd1,
    V_X    = 2'd2,
    V_Z    = 2'd3
  } val_e;

  typedef enum logic [1:0] {
    C_OFF = 2'd0,
    C_ON  = 2'd1,
    C_AMB = 2'd2
  } cond_e;

  typedef enum logic [DEV_W-1:0] {
    D_NSW  = 2'd0,
    D_PSW  = 2'd1,
    D_PAIR = 2'd2,
    D_RSVD = 2'd3
  } dev_e;

  localparam logic [STR_W-1:0] S_SUPPLY = 3'd7;
  localparam logic [STR_W-1:0] S_STRONG = 3'd6;
  localparam logic [STR_W-1:0] S_PULL   = 3'd5;
  localparam logic [STR_W-1:0] S_LARGE  = 3'd4;
  localparam logic [STR_W-1:0] S_WEAK   = 3'd3;
  localparam logic [STR_W-1:0] S_MEDIUM = 3'd2;
  localparam logic [STR_W-1:0] S_SMALL  = 3'd1;
  localparam logic [STR_W-1:0] S_HIZ    = 3'd0;
endpackage

// File: rtl/swl_ctl_decode.sv
module swl_ctl_decode
  import swl_pkg::*;
#(
  parameter bit ON_WHEN_HIGH = 1'b1
) (
  input  val_e  ctl,
  output cond_e cond
);
  generate
    if (ON_WHEN_HIGH) begin : g_nside
      always_comb begin
        unique case (ctl)
          V_ONE:   cond = C_ON;
          V_ZERO:  cond = C_OFF;
          default: cond = C_AMB;
        endcase
      end
    end else begin : g_pside
      always_comb begin
        unique case (ctl)
          V_ZERO:  cond = C_ON;
          V_ONE:   cond = C_OFF;
          default: cond = C_AMB;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/swl_str_reduce.sv
module swl_str_reduce
  import swl_pkg::*;
(
  input  logic [STR_W-1:0] str_in,
  input  logic             resistive,
  output logic [STR_W-1:0] str_out
);
  always_comb begin
    if (!resistive) begin
      str_out = (str_in == S_SUPPLY) ? S_STRONG : str_in;
    end else begin
      unique case (str_in)
        S_SUPPLY, S_STRONG: str_out = S_PULL;
        S_PULL:             str_out = S_WEAK;
        S_LARGE, S_WEAK:    str_out = S_MEDIUM;
        S_MEDIUM:           str_out = S_SMALL;
        S_SMALL:            str_out = S_SMALL;
        default:            str_out = S_HIZ;
      endcase
    end
  end
endmodule

// File: rtl/swl_cond_merge.sv
module swl_cond_merge
  import swl_pkg::*;
(
  input  cond_e n_cond,
  input  cond_e p_cond,
  input  dev_e  dev,
  output cond_e cond
);
  cond_e pair_cond;

  // Both halves see the same data: a firm path wins over an ambiguous one,
  // which in turn wins over an open one.
  always_comb begin
    if (n_cond == C_ON || p_cond == C_ON)        pair_cond = C_ON;
    else if (n_cond == C_AMB || p_cond == C_AMB) pair_cond = C_AMB;
    else                                         pair_cond = C_OFF;
  end

  always_comb begin
    unique case (dev)
      D_NSW:   cond = n_cond;
      D_PSW:   cond = p_cond;
      D_PAIR:  cond = pair_cond;
      default: cond = C_OFF;
    endcase
  end

  // R9: the pair never reports off while either side conducts firmly
  always_comb begin
    if (dev == D_PAIR && (n_cond == C_ON || p_cond == C_ON))
      p_pair_on_r9: assert (cond == C_ON);
  end
endmodule

// File: rtl/swl_device_eval.sv
module swl_device_eval
  import swl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] in_val,
  input  logic [2:0] in_str,
  input  logic [1:0] ctl_n,
  input  logic [1:0] ctl_p,
  input  logic [1:0] dev_sel,
  input  logic       resistive,
  output logic [1:0] out_val,
  output logic [2:0] out_str,
  output logic       out_l,
  output logic       out_h
);
  cond_e            n_cond, p_cond, cond;
  logic [STR_W-1:0] red_str;
  logic             data_z;
  logic [VAL_W-1:0] nxt_val;
  logic [STR_W-1:0] nxt_str;
  logic             nxt_l, nxt_h;

  swl_ctl_decode #(.ON_WHEN_HIGH(1'b1)) u_ndec (.ctl(val_e'(ctl_n)), .cond(n_cond));
  swl_ctl_decode #(.ON_WHEN_HIGH(1'b0)) u_pdec (.ctl(val_e'(ctl_p)), .cond(p_cond));

  swl_cond_merge u_merge (
    .n_cond (n_cond),
    .p_cond (p_cond),
    .dev    (dev_e'(dev_sel)),
    .cond   (cond)
  );

  swl_str_reduce u_red (
    .str_in    (in_str),
    .resistive (resistive),
    .str_out   (red_str)
  );

  assign data_z = (val_e'(in_val) == V_Z) || (in_str == S_HIZ);

  always_comb begin
    nxt_val = V_Z;
    nxt_str = S_HIZ;
    nxt_l   = 1'b0;
    nxt_h   = 1'b0;
    if (!data_z && cond != C_OFF) begin
      nxt_val = in_val;
      nxt_str = red_str;
      if (cond == C_AMB) begin
        nxt_l = (val_e'(in_val) == V_ZERO);
        nxt_h = (val_e'(in_val) == V_ONE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_val <= V_Z;
      out_str <= S_HIZ;
      out_l   <= 1'b0;
      out_h   <= 1'b0;
    end else begin
      out_val <= nxt_val;
      out_str <= nxt_str;
      out_l   <= nxt_l;
      out_h   <= nxt_h;
    end
  end

  p_z_data_r6: assert property (@(posedge clk) disable iff (rst)
    (in_val == 2'd3 || in_str == 3'd0) |=> (out_val == 2'd3 && out_str == 3'd0 && !out_l && !out_h));

  p_str_bound_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_str <= $past(in_str)));

  p_no_supply_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_str != 3'd7));

  p_resist_cap_r8: assert property (@(posedge clk) disable iff (rst)
    resistive |=> (out_str <= 3'd5));

  p_flags_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_l, out_h}) && (!out_l || out_val == 2'd0) && (!out_h || out_val == 2'd1));

  p_zstr_r11: assert property (@(posedge clk) disable iff (rst)
    (out_val == 2'd3) |-> (out_str == 3'd0));

  p_rsvd_r10: assert property (@(posedge clk) disable iff (rst)
    (dev_sel == 2'd3) |=> (out_val == 2'd3));
endmodule

// File: tb/swl_device_eval_tb.sv
`timescale 1ns/1ps
module swl_device_eval_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] in_val = 2'd3;
  logic [2:0] in_str = 3'd0;
  logic [1:0] ctl_n = 2'd0;
  logic [1:0] ctl_p = 2'd1;
  logic [1:0] dev_sel = 2'd0;
  logic       resistive = 1'b0;
  logic [1:0] out_val;
  logic [2:0] out_str;
  logic       out_l, out_h;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  swl_device_eval dut_i (
    .clk(clk), .rst(rst), .in_val(in_val), .in_str(in_str),
    .ctl_n(ctl_n), .ctl_p(ctl_p), .dev_sel(dev_sel), .resistive(resistive),
    .out_val(out_val), .out_str(out_str), .out_l(out_l), .out_h(out_h)
  );

  // 0 = off, 1 = on, 2 = ambiguous
  function automatic int side(input logic [1:0] c, input bit n_side);
    if (c == 2'd2 || c == 2'd3) return 2;
    if (n_side) return (c == 2'd1) ? 1 : 0;
    return (c == 2'd0) ? 1 : 0;
  endfunction

  function automatic logic [2:0] exp_str(input logic [2:0] s, input logic r);
    if (!r) return (s == 3'd7) ? 3'd6 : s;
    case (s)
      3'd7, 3'd6: return 3'd5;
      3'd5:       return 3'd3;
      3'd4, 3'd3: return 3'd2;
      3'd2, 3'd1: return 3'd1;
      default:    return 3'd0;
    endcase
  endfunction

  // packed {val[1:0], str[2:0], l, h}
  function automatic logic [6:0] model(input logic [1:0] v, input logic [2:0] s,
                                       input logic [1:0] cn, input logic [1:0] cp,
                                       input logic [1:0] d, input logic r);
    int ns, ps, c;
    ns = side(cn, 1'b1);
    ps = side(cp, 1'b0);
    case (d)
      2'd0: c = ns;
      2'd1: c = ps;
      2'd2: c = (ns == 1 || ps == 1) ? 1 : ((ns == 2 || ps == 2) ? 2 : 0);
      default: c = 0;
    endcase
    if (v == 2'd3 || s == 3'd0 || c == 0) return {2'd3, 3'd0, 1'b0, 1'b0};
    if (c == 1) return {v, exp_str(s, r), 1'b0, 1'b0};
    return {v, exp_str(s, r), v == 2'd0, v == 2'd1};
  endfunction

  task automatic check(input logic [6:0] exp, input string req);
    checks++;
    if ({out_val, out_str, out_l, out_h} !== exp) begin
      errors++;
      $display("FAIL %s: got val=%0d str=%0d l=%0b h=%0b, expected val=%0d str=%0d l=%0b h=%0b",
               req, out_val, out_str, out_l, out_h, exp[6:5], exp[4:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [1:0] v, input logic [2:0] s, input logic [1:0] cn,
                       input logic [1:0] cp, input logic [1:0] d, input logic r,
                       input string req);
    in_val = v; in_str = s; ctl_n = cn; ctl_p = cp; dev_sel = d; resistive = r;
    @(negedge clk);
    check(model(v, s, cn, cp, d, r), req);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd24680);
    repeat (3) @(negedge clk);
    check({2'd3, 3'd0, 1'b0, 1'b0}, "R1 reset state");
    rst = 1'b0;
    @(negedge clk);

    apply(2'd1, 3'd6, 2'd1, 2'd0, 2'd0, 1'b0, "R3 nsw on");
    check({2'd1, 3'd6, 1'b0, 1'b0}, "R3 nsw pass strong 1");
    apply(2'd0, 3'd5, 2'd0, 2'd0, 2'd0, 1'b0, "R3 nsw off");
    check({2'd3, 3'd0, 1'b0, 1'b0}, "R3 nsw off z");
    apply(2'd0, 3'd5, 2'd1, 2'd0, 2'd1, 1'b0, "R4 psw on");
    check({2'd0, 3'd5, 1'b0, 1'b0}, "R4 psw pass");
    apply(2'd1, 3'd5, 2'd0, 2'd1, 2'd1, 1'b0, "R4 psw off");
    check({2'd3, 3'd0, 1'b0, 1'b0}, "R4 psw off z");
    apply(2'd0, 3'd6, 2'd3, 2'd0, 2'd0, 1'b0, "R5 z ctl L");
    check({2'd0, 3'd6, 1'b1, 1'b0}, "R5 z ctl gives L");
    apply(2'd1, 3'd3, 2'd0, 2'd2, 2'd1, 1'b0, "R5 x ctl H");
    check({2'd1, 3'd3, 1'b0, 1'b1}, "R5 x ctl gives H");
    apply(2'd2, 3'd4, 2'd2, 2'd0, 2'd0, 1'b0, "R5 x data x ctl");
    apply(2'd1, 3'd0, 2'd1, 2'd0, 2'd0, 1'b0, "R6 strength-0 data");
    check({2'd3, 3'd0, 1'b0, 1'b0}, "R6 strength-0 data gives z");
    apply(2'd3, 3'd7, 2'd1, 2'd0, 2'd2, 1'b0, "R6 z data");
    apply(2'd1, 3'd7, 2'd1, 2'd0, 2'd0, 1'b0, "R7 supply reduced");
    check({2'd1, 3'd6, 1'b0, 1'b0}, "R7 supply to strong");
    for (int s = 1; s < 8; s++) begin
      apply(2'd0, 3'(s), 2'd1, 2'd0, 2'd0, 1'b1, "R8 resistive ladder");
      apply(2'd1, 3'(s), 2'd1, 2'd0, 2'd0, 1'b0, "R7 plain ladder");
    end
    apply(2'd1, 3'd4, 2'd0, 2'd0, 2'd2, 1'b1, "R8 resistive large");
    check({2'd1, 3'd2, 1'b0, 1'b0}, "R8 large to medium");
    for (int cn = 0; cn < 4; cn++)
      for (int cp = 0; cp < 4; cp++)
        apply(2'd0, 3'd5, 2'(cn), 2'(cp), 2'd2, 1'b0, "R9 pair control table");
    apply(2'd1, 3'd6, 2'd1, 2'd2, 2'd2, 1'b0, "R9 pair one side on");
    check({2'd1, 3'd6, 1'b0, 1'b0}, "R9 pair n on p unknown");
    apply(2'd1, 3'd6, 2'd1, 2'd0, 2'd3, 1'b0, "R10 reserved select");
    check({2'd3, 3'd0, 1'b0, 1'b0}, "R10 reserved gives z");

    for (int i = 0; i < 400; i++) begin
      apply(2'($urandom), 3'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
            1'($urandom), "R2 random");
      checks++;
      if (out_str > in_str || (out_l && out_h) || (out_val == 2'd3 && out_str != 3'd0)) begin
        errors++;
        $display("FAIL R11: got str=%0d l=%0b h=%0b val=%0d, expected bounded by in_str=%0d",
                 out_str, out_l, out_h, out_val, in_str);
      end
    end

    apply(2'd1, 3'd6, 2'd1, 2'd0, 2'd0, 1'b0, "R2 before reset");
    rst = 1'b1;
    @(negedge clk);
    check({2'd3, 3'd0, 1'b0, 1'b0}, "R1 reset mid-run");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule